// File: doc/BRIEF.md
# Chroma Planar Intra Predictor

This block produces a square block of predicted chroma samples by planar intra prediction. The Cb and Cr components travel together. Each entry of the reference array is a 16-bit pair, with Cb in bits 7:0 and Cr in bits 15:8. A start pulse carries a size code. The block then reads the reference entries it needs through an indexed read port. The port has one cycle of latency. The block then streams the predicted block out one row per beat.

Each beat carries a whole row of interleaved Cb/Cr bytes and is weighted bilinearly from four references:
- the left neighbour of the row,
- the top neighbour of the column,
- one fixed bottom-left sample,
- one fixed top-right sample.

The sum is rounded and shifted by an amount that depends on the block size. Cb and Cr use the same weights and indices, and their datapaths never mix.

The row stream follows valid/ready rules:
- Once `out_valid` rises, it stays high and `out_row`/`out_last` stay stable until a cycle in which `out_ready` is high.
- A beat transfers on a clock edge where both are high.
- `out_ready` may change freely, and `out_valid` never depends on it within a cycle.
- The size code and start are plain control pins.

Top module: `chroma_planar_pred`

## Requirements
- R1: After reset `busy`, `out_valid`, `out_last` and `done` are all low.
- R2: Size code 0, 1, 2 selects nt = 4, 8, 16. A start with code 3 is ignored: `busy` stays low and no row appears.
- R3: After an accepted start, the block drives reference indices 0 through 3nt+1 in increasing order, one per cycle, from the cycle after start. `ref_data` is taken one cycle after its index. The first row is valid 3nt+3 cycles after the start edge.
- R4: The sample at (row, col) is ((nt-1-col)*L + (col+1)*TR + (nt-1-row)*T + (row+1)*BL + nt) >> (log2(nt)+1). Here L is entry 2nt-1-row, T is entry 2nt+1+col, BL is entry nt-1 and TR is entry 3nt+1.
- R5: In `out_row`, byte 2c holds the Cb sample of column c and byte 2c+1 holds its Cr sample. Bytes for columns c >= nt are zero.
- R6: Cb results depend only on reference bits 7:0 and Cr results only on bits 15:8.
- R7: Exactly nt rows are emitted, in order row 0 to row nt-1. `out_last` is high only on row nt-1.
- R8: While `out_valid` is high and `out_ready` low, `out_valid`, `out_row` and `out_last` hold their values into the next cycle.
- R9: `done` pulses for one cycle, in the cycle after the last row transfers, and `busy` is low from that cycle. A start while busy is ignored.
- R10: All-255 references give 255 in every sample. All-zero references give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (accepted only when idle) |
| size_sel | input | 2 | Size code: 0=4, 1=8, 2=16, 3 ignored |
| busy | output | 1 | A block is being fetched or emitted |
| ref_addr | output | 6 | Reference entry index |
| ref_data | input | 16 | Reference pair one cycle after index, Cr in 15:8, Cb in 7:0 |
| out_valid | output | 1 | Row beat valid |
| out_ready | input | 1 | Consumer accepts the row beat |
| out_row | output | 256 | Row bytes, Cb/Cr interleaved from column 0 |
| out_last | output | 1 | Beat is the final row |
| done | output | 1 | One-cycle pulse after the final row transfers |

## Verification
Two kinds of internal fault show up differently.

A wrong entry in the captured reference set appears in the first row that uses it. A bad bottom-left or top-right entry corrupts every sample of row 0 at once. A bad left entry affects one row and a bad top entry one column pair.

A fault in the row counter or in the fetch counter appears within one beat:
- the weights of a row shift, so every byte of that row moves;
- `out_last` appears on the wrong beat;
- or the first beat arrives at a count other than 3nt+3.

A stall fault shows as a changed row while `out_ready` is low, in the very next cycle.

// File: rtl/planar_pkg.sv
package planar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_DRAIN, ST_EMIT} pp_state_e;
  localparam int unsigned PAIR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NT_MIN = 4;
endpackage

// File: rtl/planar_ctrl.sv
module planar_ctrl
  import planar_pkg::*;
#(
  parameter int NT_LOG_MAX = 4,
  parameter int AW = 6,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    size_sel,
  input  logic          out_ready,
  output logic          busy,
  output logic [AW-1:0] ref_addr,
  output logic          cap_en,
  output logic [AW-1:0] cap_addr,
  output logic [1:0]    size_code,
  output logic [RW:0]   nt_w,
  output logic [RW-1:0] row,
  output logic          out_valid,
  output logic          out_last,
  output logic          done
);
  localparam int MAX_CODE = NT_LOG_MAX - 2;

  pp_state_e     state;
  logic [AW-1:0] cnt;
  logic [AW-1:0] last_addr;
  logic          row_end;

  assign nt_w      = (RW+1)'(NT_MIN) << size_code;
  assign last_addr = AW'(3 * int'(nt_w) + 1);
  assign row_end   = ({1'b0, row} == nt_w - (RW+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      size_code <= '0;
      row       <= '0;
      done      <= 1'b0;
      cap_en    <= 1'b0;
      cap_addr  <= '0;
    end else begin
      done     <= 1'b0;
      cap_en   <= (state == ST_LOAD);
      cap_addr <= cnt;
      case (state)
        ST_IDLE: if (start && int'(size_sel) <= MAX_CODE) begin
          size_code <= size_sel;
          cnt       <= '0;
          state     <= ST_LOAD;
        end
        ST_LOAD: begin
          if (cnt == last_addr) state <= ST_DRAIN;
          else cnt <= cnt + 1'b1;
        end
        ST_DRAIN: begin
          row   <= '0;
          state <= ST_EMIT;
        end
        default: if (out_ready) begin
          if (row_end) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            row <= row + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign ref_addr  = cnt;
  assign out_valid = (state == ST_EMIT);
  assign out_last  = out_valid && row_end;

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> ref_addr == $past(ref_addr) + 1'b1);
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last));
  a_r2_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && int'(size_sel) > MAX_CODE) |=> state == ST_IDLE);
  a_r7_next_row: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid);
endmodule

// File: rtl/planar_ref_store.sv
module planar_ref_store
  import planar_pkg::*;
#(
  parameter int NT_MAX = 16,
  parameter int AW = 6,
  parameter int RW = 4,
  parameter int REF_N = 50
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  wr_addr,
  input  logic [PAIR_W-1:0]              wr_data,
  input  logic [RW:0]                    nt_w,
  input  logic [RW-1:0]                  row,
  output logic [PAIR_W-1:0]              left_px,
  output logic [PAIR_W-1:0]              bl_px,
  output logic [PAIR_W-1:0]              tr_px,
  output logic [NT_MAX-1:0][PAIR_W-1:0]  top_px
);
  logic [PAIR_W-1:0] refs [REF_N];
  logic [AW-1:0]     two_nt;

  always_ff @(posedge clk) begin
    if (wr_en) refs[wr_addr] <= wr_data;
  end

  assign two_nt  = AW'({nt_w, 1'b0});
  assign left_px = refs[two_nt - AW'(1) - AW'(row)];
  assign bl_px   = refs[AW'(nt_w) - AW'(1)];
  assign tr_px   = refs[AW'(3 * int'(nt_w) + 1)];

  for (genvar c = 0; c < NT_MAX; c++) begin : g_top
    assign top_px[c] = (c < int'(nt_w)) ? refs[two_nt + AW'(c + 1)] : '0;
  end
endmodule

// File: rtl/planar_row_calc.sv
module planar_row_calc
  import planar_pkg::*;
#(
  parameter int NT_MAX = 16,
  parameter int RW = 4
) (
  input  logic [1:0]                     size_code,
  input  logic [RW:0]                    nt_w,
  input  logic [RW-1:0]                  row,
  input  logic [PAIR_W-1:0]              left_px,
  input  logic [PAIR_W-1:0]              bl_px,
  input  logic [PAIR_W-1:0]              tr_px,
  input  logic [NT_MAX-1:0][PAIR_W-1:0]  top_px,
  output logic [2*NT_MAX*BYTE_W-1:0]     row_bytes
);
  logic [3:0]  shamt;
  logic [15:0] w_row_a, w_row_b;

  assign shamt   = 4'(size_code) + 4'd3;
  assign w_row_a = 16'(nt_w) - 16'(row) - 16'd1;
  assign w_row_b = 16'(row) + 16'd1;

  for (genvar c = 0; c < NT_MAX; c++) begin : g_col
    for (genvar k = 0; k < 2; k++) begin : g_comp
      logic [15:0] w_col_a, sum;
      logic [7:0]  res;
      always_comb begin
        w_col_a = 16'(nt_w) - 16'(c + 1);
        sum = w_col_a * 16'(left_px[k*BYTE_W +: BYTE_W])
            + 16'(c + 1) * 16'(tr_px[k*BYTE_W +: BYTE_W])
            + w_row_a * 16'(top_px[c][k*BYTE_W +: BYTE_W])
            + w_row_b * 16'(bl_px[k*BYTE_W +: BYTE_W])
            + 16'(nt_w);
        res = 8'(sum >> shamt);
      end
      assign row_bytes[(2*c+k)*BYTE_W +: BYTE_W] = (c < int'(nt_w)) ? res : 8'h00;
    end
  end
endmodule

// File: rtl/chroma_planar_pred.sv
module chroma_planar_pred
  import planar_pkg::*;
#(
  parameter int NT_LOG_MAX = 4,
  localparam int NT_MAX = 1 << NT_LOG_MAX,
  localparam int REF_N  = 3 * NT_MAX + 2,
  localparam int AW     = $clog2(REF_N),
  localparam int RW     = NT_LOG_MAX,
  localparam int ROW_W  = 2 * NT_MAX * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size_sel,
  output logic              busy,
  output logic [AW-1:0]     ref_addr,
  input  logic [PAIR_W-1:0] ref_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ROW_W-1:0]  out_row,
  output logic              out_last,
  output logic              done
);
  logic                          cap_en;
  logic [AW-1:0]                 cap_addr;
  logic [1:0]                    size_code;
  logic [RW:0]                   nt_w;
  logic [RW-1:0]                 row;
  logic [PAIR_W-1:0]             left_px, bl_px, tr_px;
  logic [NT_MAX-1:0][PAIR_W-1:0] top_px;

  planar_ctrl #(.NT_LOG_MAX(NT_LOG_MAX), .AW(AW), .RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .out_ready(out_ready), .busy(busy), .ref_addr(ref_addr),
    .cap_en(cap_en), .cap_addr(cap_addr), .size_code(size_code),
    .nt_w(nt_w), .row(row), .out_valid(out_valid), .out_last(out_last),
    .done(done)
  );

  planar_ref_store #(.NT_MAX(NT_MAX), .AW(AW), .RW(RW), .REF_N(REF_N)) u_store (
    .clk(clk), .wr_en(cap_en), .wr_addr(cap_addr), .wr_data(ref_data),
    .nt_w(nt_w), .row(row), .left_px(left_px), .bl_px(bl_px),
    .tr_px(tr_px), .top_px(top_px)
  );

  planar_row_calc #(.NT_MAX(NT_MAX), .RW(RW)) u_calc (
    .size_code(size_code), .nt_w(nt_w), .row(row), .left_px(left_px),
    .bl_px(bl_px), .tr_px(tr_px), .top_px(top_px), .row_bytes(out_row)
  );

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_last)));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !out_last));
endmodule

// File: tb/chroma_planar_pred_test.sv
module chroma_planar_pred_test;
  localparam int ROW_W = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        size_sel = 2'd0;
  logic              busy;
  logic [5:0]        ref_addr;
  logic [15:0]       ref_data;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [ROW_W-1:0]  out_row;
  logic              out_last;
  logic              done;

  logic [15:0] mem [0:63];
  logic [31:0] rng = 32'h1234_5678;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  chroma_planar_pred uut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel), .busy(busy),
    .ref_addr(ref_addr), .ref_data(ref_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_row(out_row), .out_last(out_last), .done(done)
  );

  always_ff @(posedge clk) ref_data <= mem[ref_addr];

  // fields: [15:14] size code, [13] back-pressure, [12:11] fill, [10] start poke, [9:0] seed
  localparam logic [15:0] VEC [8] = '{
    {2'd0, 1'b0, 2'd0, 1'b0, 10'd1},
    {2'd1, 1'b0, 2'd0, 1'b0, 10'd2},
    {2'd2, 1'b0, 2'd0, 1'b0, 10'd3},
    {2'd0, 1'b1, 2'd0, 1'b1, 10'd4},
    {2'd1, 1'b1, 2'd2, 1'b0, 10'd5},
    {2'd2, 1'b1, 2'd0, 1'b1, 10'd6},
    {2'd2, 1'b0, 2'd1, 1'b0, 10'd7},
    {2'd1, 1'b0, 2'd3, 1'b0, 10'd8}
  };

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [7:0] model(input int nt, input int r, input int c, input int k);
    int sh, sum;
    sh = (nt == 4) ? 3 : (nt == 8) ? 4 : 5;
    sum = (nt-1-c) * int'(mem[2*nt-1-r][k*8 +: 8]) + (c+1) * int'(mem[3*nt+1][k*8 +: 8])
        + (nt-1-r) * int'(mem[2*nt+1+c][k*8 +: 8]) + (r+1) * int'(mem[nt-1][k*8 +: 8]) + nt;
    return 8'(sum >> sh);
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_job(input logic [15:0] v);
    int nt, row, waitc;
    bit bp, poke, poked, prev_stall, prev_last_hs, saw_done, rdy;
    logic [ROW_W-1:0] saved, exp;
    nt = 4 << v[15:14]; bp = v[13]; poke = v[10];
    rng = 32'h9E37_79B9 ^ 32'(v[9:0]);
    for (int i = 0; i < 64; i++) begin
      rng = step(rng);
      case (v[12:11])
        2'd0: mem[i] = rng[15:0];
        2'd1: mem[i] = 16'hFFFF;
        2'd2: mem[i] = {8'h00, rng[7:0]};
        default: mem[i] = 16'h0000;
      endcase
    end
    @(negedge clk); start = 1'b1; size_sel = v[15:14];
    @(negedge clk); start = 1'b0;
    waitc = 0;
    while (!out_valid && waitc < 200) begin @(negedge clk); waitc++; end
    check(waitc == 3*nt+3, "R3 first-row latency", 256'(waitc), 256'(3*nt+3));
    row = 0; poked = 0; prev_stall = 0; prev_last_hs = 0; saw_done = 0;
    for (int it = 0; it < 400 && !saw_done; it++) begin
      if (done) begin
        saw_done = 1;
        check(prev_last_hs && !busy, "R9 done after last row", {busy, prev_last_hs}, 2'b01);
      end else begin
        if (prev_stall)
          check(out_valid && out_row == saved, "R8 hold under stall", out_row, saved);
        rng = step(rng);
        rdy = bp ? rng[3] : 1'b1;
        out_ready = rdy;
        if (poke && !poked && row == 1) begin
          start = 1'b1; size_sel = v[15:14] ^ 2'd1; poked = 1;
        end else start = 1'b0;
        if (out_valid && rdy) begin
          exp = '0;
          for (int c = 0; c < nt; c++)
            for (int k = 0; k < 2; k++) exp[(2*c+k)*8 +: 8] = model(nt, row, c, k);
          check(out_row == exp, $sformatf("R4/R5/R6/R10 row %0d nt %0d", row, nt), out_row, exp);
          check(out_last == (row == nt-1), "R7 last flag", 256'(out_last), 256'(row == nt-1));
          row++;
        end
        prev_last_hs = out_valid && rdy && out_last;
        prev_stall = out_valid && !rdy;
        saved = out_row;
        @(negedge clk);
      end
    end
    start = 1'b0; out_ready = 1'b1;
    check(saw_done && row == nt, "R7 row count", 256'(row), 256'(nt));
    @(negedge clk);
    @(negedge clk);
    check(!busy && !done && !out_valid, "R9 no restart after poke", {busy, done, out_valid}, 3'b000);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !out_last && !done, "R1 reset state",
          {busy, out_valid, out_last, done}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1; size_sel = 2'd3;
    @(negedge clk); start = 1'b0;
    begin
      bit quiet = 1;
      for (int i = 0; i < 6; i++) begin
        if (busy || out_valid) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R2 code 3 ignored", 256'(quiet), 256'(1));
    end
    for (int j = 0; j < 8; j++) run_job(VEC[j]);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule